// File: doc/BRIEF.md
# Rotate-and-Mask Word Unit

This block is a 32-bit datapath slice that rotates a source word left by a 5-bit amount. It then applies a contiguous mask defined by a start index and a stop index. Indices count from the most significant bit, so index 0 is `src_word[31]` and index 31 is `src_word[0]`. When the start index is greater than the stop index, the run of ones wraps past the least significant end and continues from the most significant end.

The unit has two ways of combining the rotated word with the mask. In clearing mode, bits outside the mask are forced to zero. In merging mode, bits outside the mask are taken from a separate target word, and the rotated bits fill the masked span. The rotate amount comes either from an immediate field or from the low five bits of a register operand.

A one-cycle output register can be turned on or off by a parameter; the default turns it on. Three record flags classify the result as zero, negative or positive. Plain shifts, clears and field extracts can all be expressed through the rotate amount and the two indices.

Top module: `rtm_unit`

## Requirements
- R1: The source word is rotated circularly left by the effective amount; an amount of 0 returns the source unchanged (with indices 0 and 31).
- R2: When `use_reg_shamt` is 1 the effective amount is `shamt_reg[4:0]` and `shamt_reg[31:5]` has no effect; when 0 it is `shamt_imm`.
- R3: With start index <= stop index, the mask has ones exactly at indices start..stop, where index i corresponds to vector bit 31-i.
- R4: With start index > stop index, the mask has ones at indices start..31 and 0..stop (start=29, stop=6 gives seven leading and three trailing ones).
- R5: With `insert_mode`=0, every result bit outside the mask is 0 and every bit inside equals the rotated bit.
- R6: With `insert_mode`=1, every result bit outside the mask equals the matching `dst_word` bit, and every bit inside equals the rotated bit.
- R7: Start 0 with stop 31 gives an all-ones mask, so the result is the pure rotation in either mode.
- R8: A left shift by n equals rotate n with indices 0..31-n; a logical right shift by n equals rotate 32-n with indices n..31.
- R9: Exactly one of `rec_zero` (result is 0), `rec_neg` (result bit 31 set) and `rec_pos` (otherwise) is 1 whenever `out_valid` is 1.
- R10: With REG_OUT=1, the result and flags appear one cycle after an `in_valid` cycle and hold while `in_valid` is 0. After reset, `out_valid`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe and output register enable |
| src_word | input | 32 | Word to rotate |
| dst_word | input | 32 | Target word whose unmasked bits survive in merging mode |
| shamt_imm | input | 5 | Immediate rotate amount |
| shamt_reg | input | 32 | Register operand; only the low 5 bits are used |
| use_reg_shamt | input | 1 | Selects the register operand as the rotate amount |
| mask_begin | input | 5 | Index of the first mask one (0 = MSB) |
| mask_end | input | 5 | Index of the last mask one (0 = MSB) |
| insert_mode | input | 1 | 0 = clear outside mask, 1 = keep target bits outside mask |
| out_valid | output | 1 | Result is present on the outputs |
| result | output | 32 | Masked rotated word |
| rec_zero | output | 1 | Result equals zero |
| rec_neg | output | 1 | Result bit 31 is set |
| rec_pos | output | 1 | Result is nonzero with bit 31 clear |

## Verification
On every cycle, the assertions check the following properties of each captured operation: bits outside the mask are cleared or preserved according to the mode, a full mask yields the exact rotation, the record flags are exclusive and agree with the result, and the register holds its value while idle. The assertions build the mask by shifting an all-ones word, so they share no logic with the design. Only the bench's sweeps can show that each in-mask bit lands in the right place for every combination of amount and indices, including every wrap. The bench scenarios also cover the register-operand selection with garbage in the upper bits, the shift idioms and the reset values.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  typedef enum logic {
    MODE_CLEAR = 1'b0,
    MODE_MERGE = 1'b1
  } merge_mode_e;

  typedef struct packed {
    logic zero;
    logic neg;
    logic pos;
  } rec_flags_t;
endpackage

// File: rtl/rtm_rotator.sv
module rtm_rotator #(
  parameter int XLEN  = 32,
  parameter int IDX_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  din,
  input  logic [IDX_W-1:0] amt,
  output logic [XLEN-1:0]  dout
);
  logic [XLEN-1:0] stage [0:IDX_W];

  assign stage[0] = din;

  for (genvar k = 0; k < IDX_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt[k]
      ? {stage[k][XLEN-1-STEP:0], stage[k][XLEN-1:XLEN-STEP]}
      : stage[k];
  end

  assign dout = stage[IDX_W];
endmodule

// File: rtl/rtm_maskgen.sv
module rtm_maskgen #(
  parameter int XLEN  = 32,
  parameter int IDX_W = $clog2(XLEN)
) (
  input  logic [IDX_W-1:0] idx_first,
  input  logic [IDX_W-1:0] idx_last,
  output logic [XLEN-1:0]  mask
);
  logic wraps;
  assign wraps = idx_first > idx_last;

  for (genvar p = 0; p < XLEN; p++) begin : g_bit
    localparam logic [IDX_W-1:0] POS = IDX_W'(p);
    logic ge_first, le_last;
    assign ge_first = POS >= idx_first;
    assign le_last  = POS <= idx_last;
    assign mask[XLEN-1-p] = wraps ? (ge_first | le_last) : (ge_first & le_last);
  end
endmodule

// File: rtl/rtm_merge.sv
module rtm_merge
  import rtm_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] rotated,
  input  logic [XLEN-1:0] mask,
  input  logic [XLEN-1:0] target,
  input  merge_mode_e     mode,
  output logic [XLEN-1:0] merged,
  output rec_flags_t      flags
);
  logic [XLEN-1:0] keep;

  always_comb begin
    keep   = (mode == MODE_MERGE) ? (target & ~mask) : '0;
    merged = (rotated & mask) | keep;
    flags.zero = (merged == '0);
    flags.neg  = merged[XLEN-1];
    flags.pos  = ~flags.zero & ~merged[XLEN-1];
  end
endmodule

// File: rtl/rtm_unit.sv
module rtm_unit
  import rtm_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int IDX_W  = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [XLEN-1:0]  src_word,
  input  logic [XLEN-1:0]  dst_word,
  input  logic [IDX_W-1:0] shamt_imm,
  input  logic [XLEN-1:0]  shamt_reg,
  input  logic             use_reg_shamt,
  input  logic [IDX_W-1:0] mask_begin,
  input  logic [IDX_W-1:0] mask_end,
  input  logic             insert_mode,
  output logic             out_valid,
  output logic [XLEN-1:0]  result,
  output logic             rec_zero,
  output logic             rec_neg,
  output logic             rec_pos
);
  logic [IDX_W-1:0] eff_amt;
  logic [XLEN-1:0]  rot_word, mask_word, nxt_result;
  rec_flags_t       nxt_flags;
  merge_mode_e      mode;
  logic             unused_shamt_hi;

  assign unused_shamt_hi = ^shamt_reg[XLEN-1:IDX_W];
  assign eff_amt = use_reg_shamt ? shamt_reg[IDX_W-1:0] : shamt_imm;
  assign mode    = insert_mode ? MODE_MERGE : MODE_CLEAR;

  rtm_rotator #(.XLEN(XLEN), .IDX_W(IDX_W)) u_rot (
    .din  (src_word),
    .amt  (eff_amt),
    .dout (rot_word)
  );

  rtm_maskgen #(.XLEN(XLEN), .IDX_W(IDX_W)) u_mask (
    .idx_first (mask_begin),
    .idx_last  (mask_end),
    .mask      (mask_word)
  );

  rtm_merge #(.XLEN(XLEN)) u_merge (
    .rotated (rot_word),
    .mask    (mask_word),
    .target  (dst_word),
    .mode    (mode),
    .merged  (nxt_result),
    .flags   (nxt_flags)
  );

  if (REG_OUT) begin : g_reg
    logic            rst_meta, rst_sync_n;
    logic            q_valid;
    logic [XLEN-1:0] q_result;
    rec_flags_t      q_flags;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rst_meta   <= 1'b0;
        rst_sync_n <= 1'b0;
      end else begin
        rst_meta   <= 1'b1;
        rst_sync_n <= rst_meta;
      end
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        q_valid  <= 1'b0;
        q_result <= '0;
        q_flags  <= '0;
      end else begin
        q_valid <= in_valid;
        if (in_valid) begin
          q_result <= nxt_result;
          q_flags  <= nxt_flags;
        end
      end
    end

    assign out_valid = q_valid;
    assign result    = q_result;
    assign rec_zero  = q_flags.zero;
    assign rec_neg   = q_flags.neg;
    assign rec_pos   = q_flags.pos;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign out_valid  = in_valid;
    assign result     = nxt_result;
    assign rec_zero   = nxt_flags.zero;
    assign rec_neg    = nxt_flags.neg;
    assign rec_pos    = nxt_flags.pos;
  end
endmodule

// File: rtl/rtm_unit_chk.sv
module rtm_unit_chk #(
  parameter int XLEN    = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int IDX_W  = $clog2(XLEN)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [XLEN-1:0]  src_word,
  input logic [XLEN-1:0]  dst_word,
  input logic [IDX_W-1:0] shamt_imm,
  input logic [XLEN-1:0]  shamt_reg,
  input logic             use_reg_shamt,
  input logic [IDX_W-1:0] mask_begin,
  input logic [IDX_W-1:0] mask_end,
  input logic             insert_mode,
  input logic             out_valid,
  input logic [XLEN-1:0]  result,
  input logic             rec_zero,
  input logic             rec_neg,
  input logic             rec_pos
);
  logic [XLEN-1:0]   c_src, c_dst;
  logic [IDX_W-1:0]  c_amt, c_mb, c_me;
  logic              c_ins;
  logic [IDX_W-1:0]  in_amt;
  logic [XLEN-1:0]   ones, from_mb, to_me, cmask, crot;
  logic [2*XLEN-1:0] dbl;

  assign in_amt = use_reg_shamt ? shamt_reg[IDX_W-1:0] : shamt_imm;

  if (REG_OUT) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_src <= '0; c_dst <= '0; c_amt <= '0;
        c_mb  <= '0; c_me  <= '0; c_ins <= 1'b0;
      end else if (in_valid) begin
        c_src <= src_word; c_dst <= dst_word; c_amt <= in_amt;
        c_mb  <= mask_begin; c_me <= mask_end; c_ins <= insert_mode;
      end
    end

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
    p_valid_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
  end else begin : g_pass
    assign c_src = src_word;  assign c_dst = dst_word;  assign c_amt = in_amt;
    assign c_mb  = mask_begin; assign c_me = mask_end;  assign c_ins = insert_mode;
  end

  assign ones    = '1;
  assign from_mb = ones >> c_mb;
  assign to_me   = ones << (XLEN - 1 - int'(c_me));
  assign cmask   = (c_mb <= c_me) ? (from_mb & to_me) : (from_mb | to_me);
  assign dbl     = {c_src, c_src} << c_amt;
  assign crot    = dbl[2*XLEN-1:XLEN];

  p_clear_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !c_ins) |-> ((result & ~cmask) == '0));
  p_keep_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && c_ins) |-> ((result & ~cmask) == (c_dst & ~cmask)));
  p_full_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && c_mb == '0 && c_me == IDX_W'(XLEN-1)) |-> (result == crot));
  p_rec_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({rec_zero, rec_neg, rec_pos}));
  p_rec_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rec_zero == (result == '0)));
endmodule

bind rtm_unit rtm_unit_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_word(src_word),
  .dst_word(dst_word), .shamt_imm(shamt_imm), .shamt_reg(shamt_reg),
  .use_reg_shamt(use_reg_shamt), .mask_begin(mask_begin), .mask_end(mask_end),
  .insert_mode(insert_mode), .out_valid(out_valid), .result(result),
  .rec_zero(rec_zero), .rec_neg(rec_neg), .rec_pos(rec_pos)
);

// File: tb/rtm_unit_test.sv
module rtm_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] src_word, dst_word, shamt_reg;
  logic [4:0]  shamt_imm, mask_begin, mask_end;
  logic        use_reg_shamt, insert_mode;
  logic        out_valid, rec_zero, rec_neg, rec_pos;
  logic [31:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  rtm_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_word(src_word),
    .dst_word(dst_word), .shamt_imm(shamt_imm), .shamt_reg(shamt_reg),
    .use_reg_shamt(use_reg_shamt), .mask_begin(mask_begin), .mask_end(mask_end),
    .insert_mode(insert_mode), .out_valid(out_valid), .result(result),
    .rec_zero(rec_zero), .rec_neg(rec_neg), .rec_pos(rec_pos)
  );

  function automatic logic [31:0] ref_mask(int first, int last);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) begin
      if (first <= last) begin
        if (i >= first && i <= last) m[31-i] = 1'b1;
      end else begin
        if (i >= first || i <= last) m[31-i] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic [31:0] ref_rot(logic [31:0] v, int n);
    logic [31:0] r = v;
    for (int i = 0; i < n; i++) r = {r[30:0], r[31]};
    return r;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] s, logic [31:0] d, int amt, bit via_reg,
                       logic [26:0] hi_junk, int mb, int me, bit ins);
    @(negedge clk);
    src_word      = s;
    dst_word      = d;
    use_reg_shamt = via_reg;
    shamt_reg     = via_reg ? {hi_junk, 5'(amt)} : {hi_junk, 5'(~amt)};
    shamt_imm     = via_reg ? 5'(~amt) : 5'(amt);
    mask_begin    = 5'(mb);
    mask_end      = 5'(me);
    insert_mode   = ins;
    in_valid      = 1'b1;
    @(negedge clk);
    in_valid      = 1'b0;
  endtask

  function automatic logic [31:0] ref_result(logic [31:0] s, logic [31:0] d,
                                             int amt, int mb, int me, bit ins);
    logic [31:0] m = ref_mask(mb, me);
    logic [31:0] r = ref_rot(s, amt) & m;
    if (ins) r = r | (d & ~m);
    return r;
  endfunction

  task automatic check_flags(string req, logic [31:0] exp);
    logic [2:0] e;
    e = (exp == 0) ? 3'b100 : (exp[31] ? 3'b010 : 3'b001);
    check(req, {29'd0, rec_zero, rec_neg, rec_pos}, {29'd0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, d, e;
    rst_n = 1'b0; in_valid = 1'b0; src_word = '0; dst_word = '0;
    shamt_reg = '0; shamt_imm = '0; use_reg_shamt = 1'b0;
    mask_begin = '0; mask_end = '0; insert_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset values
    check("R10 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R10 reset result", result, 32'd0);
    check("R10 reset flags", {29'd0, rec_zero, rec_neg, rec_pos}, 32'd0);

    // R1: amount 0 passes the source
    s = 32'hDEAD_BEEF;
    apply(s, 32'h0, 0, 1'b0, 27'h0, 0, 31, 1'b0);
    check("R1 zero rotate", result, s);
    check("R10 valid after strobe", {31'd0, out_valid}, 32'd1);

    // R10: idle strobe leaves output held
    src_word = 32'h1234_5678; mask_begin = 5'd3;
    @(negedge clk);
    check("R10 hold while idle", result, s);

    // R7: full mask is a pure rotate in both modes
    apply(32'h8000_0001, 32'hFFFF_FFFF, 12, 1'b0, 27'h0, 0, 31, 1'b1);
    check("R7 full mask merge", result, 32'h0000_1800);
    apply(32'hF000_000F, 32'h0, 4, 1'b0, 27'h0, 0, 31, 1'b0);
    check("R7 full mask clear", result, 32'h0000_00FF);

    // R8: shift idioms
    s = 32'hA5C3_9E71;
    apply(s, 32'h0, 8, 1'b0, 27'h0, 0, 23, 1'b0);
    check("R8 left shift 8", result, s << 8);
    apply(s, 32'h0, 27, 1'b0, 27'h0, 5, 31, 1'b0);
    check("R8 right shift 5", result, s >> 5);

    // R4: documented wrap example, all-ones source
    apply(32'hFFFF_FFFF, 32'h0, 0, 1'b0, 27'h0, 29, 6, 1'b0);
    check("R4 wrap 29..6", result, 32'hFE00_0007);

    // R2: register amount with junk upper bits
    s = 32'h0000_00F1;
    apply(s, 32'h0, 3, 1'b1, 27'h5A5_A5A5, 0, 31, 1'b0);
    check("R2 register amount", result, 32'h0000_0788);

    // R9: record flags
    apply(32'h0, 32'h0, 0, 1'b0, 27'h0, 0, 31, 1'b0);
    check_flags("R9 zero", 32'h0);
    apply(32'h8000_0000, 32'h0, 0, 1'b0, 27'h0, 0, 31, 1'b0);
    check_flags("R9 negative", 32'h8000_0000);
    apply(32'h0000_0001, 32'h0, 0, 1'b0, 27'h0, 0, 31, 1'b0);
    check_flags("R9 positive", 32'h1);

    // R3 R4 R5 R6 R2: sweep of every amount and index pair
    for (int amt = 0; amt < 32; amt++) begin
      for (int mb = 0; mb < 32; mb++) begin
        for (int me = 0; me < 32; me++) begin
          bit ins, via;
          ins = 1'((amt + mb + me) & 1);
          via = 1'((mb ^ me) & 1);
          s = $urandom;
          d = $urandom;
          apply(s, d, amt, via, 27'($urandom), mb, me, ins);
          e = ref_result(s, d, amt, mb, me, ins);
          if (mb > me)
            check(ins ? "R4 R6 R2 wrap merge" : "R4 R5 R2 wrap clear", result, e);
          else
            check(ins ? "R3 R6 R2 span merge" : "R3 R5 R2 span clear", result, e);
          check_flags("R9 sweep flags", e);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule